// File: doc/BRIEF.md
# Sound Event Trigger Register Controller

This block is the trigger front end of a sound playback engine. A host talks to it over a small register bus with an address, write and read strobes, and a byte of data. Writing a 7-bit code to the trigger register forms an 8-bit sound vector in the upper half of the vector space. The vector goes into a one-entry slot, and that slot offers it to the playback engine with a valid/accept handshake.

After each accepted trigger a ready flag drops, and any host write made while it is low is thrown away. The flag rises again once the slot has drained and, if the timeout is enabled, once a hold-off counter has run out. Five external event pins can also fire triggers. Each pin has its own edge polarity, and each pin maps to a fixed vector. A second register holds the polarities and the timeout enable, and it reports whether the engine is playing.

Top module: `snd_trig_ctrl`

## Requirements
- R1: After reset the trigger register (address 0) reads 80h, the property register (address 1) reads 00h, and vec_valid_o is low.
- R2: Reading address 0 returns the ready flag in bit 7 and the last accepted host code in bits 6:0. Bit 7 of the write data has no effect.
- R3: A host write to address 0 while ready is 0 is ignored. The stored code is unchanged and no vector is queued, either then or later.
- R4: When the timeout enable is set, ready returns to 1 exactly TIMEOUT_CYC+1 clocks after the edge that accepted a trigger, provided the engine has already taken the vector.
- R5: An accepted host code n is presented one clock later as vec_data_o = 80h + n with vec_valid_o high.
- R6: Bits 4:0 of address 1 hold the per-pin polarity, where 0 selects a rising edge and 1 selects a falling edge. These bits read back as written.
- R7: Bit 5 of address 1 reads play_busy_i. Writing that bit has no effect.
- R8: Bit 6 of address 1 is the write-only timeout enable, and it always reads 0.
- R9: With the timeout disabled, ready returns to 1 one clock after the clock edge on which the engine accepts the vector.
- R10: A selected edge on event pin k is queued as vector PIN_VEC[k] three clocks after the pin changes, but only while ready is 1. Otherwise the edge is dropped. When several pins fire together, the lowest index wins.
- R11: If a host write to address 0 and a pin event fall in the same cycle, the host code is queued and the pin event is dropped.
- R12: vec_valid_o stays high, with vec_data_o stable, until vec_accept_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address (0 trigger, 1 property) |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational, zero when not reading |
| evt_pins_i | input | 5 | Asynchronous event pins |
| play_busy_i | input | 1 | Playback engine is sounding |
| vec_valid_o | output | 1 | Vector slot holds a vector |
| vec_data_o | output | 8 | Sound vector |
| vec_accept_i | input | 1 | Engine takes the vector |

## Verification
The bench targets the windows in which a trigger can be lost or doubled. It writes while ready is low, which a design that only tests slot occupancy would queue. It makes a pin edge coincide with a host write, where a design without priority would emit the pin vector. It raises a pin while the block is busy, and a design that latches pending edges would replay that edge later. It counts the exact hold-off length in both timeout modes, which catches off-by-one reload or release logic. It also checks the code offset at the 00h and 7Fh endpoints, the write-only and read-only property bits, and the polarity inversion, since a design that ignores polarity fires on the wrong pin transition.

// File: rtl/snd_trig_pkg.sv
package snd_trig_pkg;
  localparam int unsigned ADDR_W        = 2;
  localparam int unsigned REG_W         = 8;
  localparam int unsigned PROP_BUSY_BIT = 5;
  localparam int unsigned PROP_TMO_BIT  = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_TRIG = 2'd0,
    REG_PROP = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/snd_pin_edge.sv
module snd_pin_edge #(
  parameter int unsigned NUM_PINS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] pol_i,
  output logic [NUM_PINS-1:0] edge_o
);
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pins_i[k];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    // pol 0: rising, pol 1: falling
    assign edge_o[k] = pol_i[k] ? (prev_q & ~sync_q) : (sync_q & ~prev_q);

    p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o[k] |=> !edge_o[k]);
  end
endmodule

// File: rtl/snd_holdoff.sv
module snd_holdoff #(
  parameter int unsigned       TMR_W       = 16,
  parameter logic [TMR_W-1:0]  TIMEOUT_CYC = 16'd20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tmo_en_i,
  input  logic slot_busy_i,
  output logic ready_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else if (start_i) begin
      ready_q <= 1'b0;
      cnt_q   <= tmo_en_i ? TIMEOUT_CYC : '0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (!ready_q && cnt_q == '0 && !slot_busy_i) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  p_cnt_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> !ready_o);
  p_slot_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_busy_i |-> !ready_o);
endmodule

// File: rtl/snd_vec_slot.sv
module snd_vec_slot #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic             accept_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && accept_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/snd_trig_ctrl.sv
module snd_trig_ctrl
  import snd_trig_pkg::*;
#(
  parameter int unsigned                  TMR_W       = 16,
  parameter logic [TMR_W-1:0]             TIMEOUT_CYC = 16'd20,
  parameter int unsigned                  NUM_PINS    = 5,
  parameter int unsigned                  VEC_W       = 8,
  parameter logic [NUM_PINS*VEC_W-1:0]    PIN_VEC     = 40'h50_40_30_20_10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic [NUM_PINS-1:0] evt_pins_i,
  input  logic                play_busy_i,
  output logic                vec_valid_o,
  output logic [VEC_W-1:0]    vec_data_o,
  input  logic                vec_accept_i
);
  localparam int unsigned CODE_W = VEC_W - 1;

  logic [CODE_W-1:0]   code_q;
  logic [NUM_PINS-1:0] pol_q;
  logic                tmo_en_q;
  logic                ready;
  logic [NUM_PINS-1:0] pin_edge;
  logic                wr_trig, wr_prop, host_take, pin_hit, pin_take, start;
  logic [VEC_W-1:0]    pin_vec, load_vec;
  logic                unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[REG_W-1], reg_wdata_i[PROP_BUSY_BIT]};

  assign wr_trig   = reg_wr_i && (reg_addr_i == REG_TRIG);
  assign wr_prop   = reg_wr_i && (reg_addr_i == REG_PROP);
  assign host_take = wr_trig && ready;
  assign pin_hit   = |pin_edge;
  assign pin_take  = ready && pin_hit && !wr_trig;  // host write has priority
  assign start     = host_take || pin_take;

  // lowest index wins
  always_comb begin
    pin_vec = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (pin_edge[k]) pin_vec = PIN_VEC[k*VEC_W +: VEC_W];
    end
  end

  assign load_vec = host_take ? {1'b1, reg_wdata_i[CODE_W-1:0]} : pin_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      pol_q    <= '0;
      tmo_en_q <= 1'b0;
    end else begin
      if (host_take) code_q <= reg_wdata_i[CODE_W-1:0];
      if (wr_prop) begin
        pol_q    <= reg_wdata_i[NUM_PINS-1:0];
        tmo_en_q <= reg_wdata_i[PROP_TMO_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        REG_TRIG: reg_rdata_o = {ready, code_q};
        REG_PROP: begin
          reg_rdata_o[NUM_PINS-1:0]  = pol_q;
          reg_rdata_o[PROP_BUSY_BIT] = play_busy_i;
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  snd_pin_edge #(.NUM_PINS(NUM_PINS)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (evt_pins_i),
    .pol_i  (pol_q),
    .edge_o (pin_edge)
  );

  snd_holdoff #(.TMR_W(TMR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) i_holdoff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .tmo_en_i    (tmo_en_q),
    .slot_busy_i (vec_valid_o),
    .ready_o     (ready)
  );

  snd_vec_slot #(.VEC_W(VEC_W)) i_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .data_i   (load_vec),
    .accept_i (vec_accept_i),
    .valid_o  (vec_valid_o),
    .data_o   (vec_data_o)
  );

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_trig && !ready) |=> $stable(code_q));
  p_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_take |=> (vec_valid_o && vec_data_o == {1'b1, $past(reg_wdata_i[CODE_W-1:0])}));
  p_no_load_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready && !vec_valid_o) |=> !vec_valid_o);
endmodule

// File: tb/test_snd_trig_ctrl.sv
module test_snd_trig_ctrl;
  localparam int TMO = 20;
  localparam logic [39:0] PV = 40'h50_40_30_20_10;
  localparam logic [15:0] TBL [6] = '{16'h0080, 16'h0181, 16'h2AAA,
                                      16'h55D5, 16'h7EFE, 16'hFFFF};

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0, busy = 0, acc = 0;
  logic [7:0] wdata = 0, rdata, vdata;
  logic [4:0] pins = 0;
  logic       vvalid;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  snd_trig_ctrl #(.TIMEOUT_CYC(16'(TMO)), .PIN_VEC(PV)) i_snd_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_pins_i(pins), .play_busy_i(busy), .vec_valid_o(vvalid),
    .vec_data_o(vdata), .vec_accept_i(acc));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    tick();
    wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1;
    #1 d = rdata;
    rd = 0;
  endtask

  task automatic wait_ready();
    logic [7:0] r;
    for (int i = 0; i < 200; i++) begin
      rreg(2'd0, r);
      if (r[7]) break;
      tick();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    tick(2);
    rst_n = 1;
    tick();
    // R1 reset state
    rreg(2'd0, r); chk("R1 trig reset", r, 8'h80);
    rreg(2'd1, r); chk("R1 prop reset", r, 8'h00);
    chk("R1 valid reset", {7'd0, vvalid}, 8'h00);

    // table walk: R2 R5 R9 R12 with timeout off
    foreach (TBL[i]) begin
      acc = 0;
      wreg(2'd0, TBL[i][15:8]);
      chk("R5 valid", {7'd0, vvalid}, 8'h01);
      chk("R5 vector", vdata, TBL[i][7:0]);
      rreg(2'd0, r); chk("R2 busy code", r, {1'b0, TBL[i][14:8]});
      tick();
      chk("R12 hold valid", {7'd0, vvalid}, 8'h01);
      chk("R12 hold data", vdata, TBL[i][7:0]);
      acc = 1;
      tick();
      chk("R12 drop on accept", {7'd0, vvalid}, 8'h00);
      rreg(2'd0, r); chk("R9 not yet ready", r, {1'b0, TBL[i][14:8]});
      tick();
      rreg(2'd0, r); chk("R9 ready after one clock", r, {1'b1, TBL[i][14:8]});
      acc = 0;
    end

    // R3 write while not ready
    wreg(2'd0, 8'h11);
    wreg(2'd0, 8'h22);
    chk("R3 vector kept", vdata, 8'h91);
    rreg(2'd0, r); chk("R3 code kept", r, 8'h11);
    acc = 1;
    tick(2);
    rreg(2'd0, r); chk("R3 ready", r, 8'h91);
    tick(3);
    chk("R3 nothing queued", {7'd0, vvalid}, 8'h00);

    // R6 R7 R8 property register
    wreg(2'd1, 8'h7F);
    rreg(2'd1, r); chk("R8 R6 prop read", r, 8'h1F);
    busy = 1;
    rreg(2'd1, r); chk("R7 busy bit", r, 8'h3F);
    busy = 0;
    wreg(2'd1, 8'h40);
    rreg(2'd1, r); chk("R8 enable write-only", r, 8'h00);

    // R4 timeout enabled
    wreg(2'd0, 8'h05);
    n = 0;
    rreg(2'd0, r);
    while (!r[7] && n < 100) begin
      tick(); n++;
      rreg(2'd0, r);
    end
    chk("R4 holdoff length", 8'(n), 8'(TMO + 1));
    wreg(2'd1, 8'h00);
    acc = 0;

    // R10 rising edge on pin 2
    pins[2] = 1;
    tick(2);
    chk("R10 latency not early", {7'd0, vvalid}, 8'h00);
    tick();
    chk("R10 pin valid", {7'd0, vvalid}, 8'h01);
    chk("R10 pin vector", vdata, 8'h30);
    acc = 1; tick(2); wait_ready(); acc = 0;

    // R6 falling edge on pin 2
    wreg(2'd1, 8'h04);
    pins[2] = 0;
    tick(3);
    chk("R6 falling fires", vdata, 8'h30);
    chk("R6 falling valid", {7'd0, vvalid}, 8'h01);
    acc = 1; tick(2); wait_ready(); acc = 0;
    pins[2] = 1;
    tick(5);
    chk("R6 rising ignored", {7'd0, vvalid}, 8'h00);

    // R10 simultaneous pins, lowest wins
    pins[1] = 1; pins[3] = 1;
    tick(3);
    chk("R10 priority", vdata, 8'h20);
    acc = 1; tick(2); wait_ready(); tick(3);
    chk("R10 single event", {7'd0, vvalid}, 8'h00);
    acc = 0;

    // R10 edge dropped while not ready
    wreg(2'd0, 8'h33);
    pins[4] = 1;
    tick(5);
    acc = 1; tick(2); wait_ready(); tick(4);
    chk("R10 busy edge dropped", {7'd0, vvalid}, 8'h00);
    acc = 0;

    // R11 host and pin in same cycle
    pins[0] = 1;
    tick(2);
    wreg(2'd0, 8'h44);
    chk("R11 host wins", vdata, 8'hC4);
    acc = 1; tick(2); wait_ready(); tick(4);
    chk("R11 pin dropped", {7'd0, vvalid}, 8'h00);
    acc = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule